// File: doc/BRIEF.md
# Audio Settings Register Bank with I2C Write Target

This block is a write-only I2C target that holds the control settings of a two-channel audio path: master volume, a separate attenuation for each speaker, loudness, bass and treble. A controller writes to it with the standard address byte and then any number of command bytes in one transaction. The leading bits of each command byte select the setting it changes. The block conditions the raw SCL and SDA pins with a system clock and finds START and STOP. It acknowledges its own address and every data byte that follows. The settings appear on its outputs as latched fields, together with a mute flag for each speaker.

After reset, every setting holds a safe value: volume at maximum attenuation, both speakers muted, loudness off, and both tone controls at 0 dB. SDA is open-drain. The block only ever pulls it low, through `sda_drive_low`, and reads the resolved line on `sda_in`. The system clock must run at least ten times faster than SCL.

Top module: `i2c_audio_regbank`

## Requirements
- R1: After reset the outputs are: vol_coarse=7, vol_fine=7, both speaker coarse fields=3 and fine fields=7, loud_on=0, bass_code=4'b1111 and treble_code=4'b1111 (the 0 dB code), and mute_l=mute_r=1.
- R2: An address byte of 0x88 (7-bit address 7'h44 with the write bit 0) is acknowledged. The block holds sda_drive_low high through the ninth SCL pulse of that byte and of every data byte that follows it.
- R3: After an address byte with a different address, or with the read bit set, the block gives no acknowledge and ignores every byte until the next START.
- R4: A data byte 00_ccc_fff sets vol_coarse to bits [5:3] (10 dB steps) and vol_fine to bits [2:0] (1.25 dB steps).
- R5: A data byte 100_cc_fff sets the left speaker and 101_cc_fff sets the right speaker. The coarse field takes bits [4:3] and the fine field takes bits [2:0].
- R6: mute_l (mute_r) is high exactly when that speaker's coarse field is 2'b11 and its fine field is 3'b111.
- R7: A data byte 010_xx_L_xx sets loud_on to the inverse of bit 2, so L=0 turns loudness on. Bits 4, 3, 1 and 0 are ignored.
- R8: A data byte 0110_cccc loads bass_code and 0111_cccc loads treble_code with bits [3:0] unchanged. Codes 0000 to 0111 mean -14 dB up to 0 dB, and codes 1111 down to 1000 mean 0 dB up to +14 dB.
- R9: A data byte whose two top bits are 11 changes no output.
- R10: Several data bytes in one transaction are each applied, in the order they were sent.
- R11: A data byte changes the outputs only after its acknowledge clock has ended. A START or STOP in the middle of a byte discards the partial byte.
- R12: sda_drive_low is asserted and released only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Raw I2C clock line |
| sda_in | input | 1 | Resolved I2C data line |
| sda_drive_low | output | 1 | Pull SDA low (open-drain acknowledge) |
| vol_coarse | output | 3 | Volume, 10 dB steps |
| vol_fine | output | 3 | Volume, 1.25 dB steps |
| spk_l_coarse | output | 2 | Left speaker attenuation, 10 dB steps |
| spk_l_fine | output | 3 | Left speaker attenuation, 1.25 dB steps |
| spk_r_coarse | output | 2 | Right speaker attenuation, 10 dB steps |
| spk_r_fine | output | 3 | Right speaker attenuation, 1.25 dB steps |
| loud_on | output | 1 | Loudness enabled |
| bass_code | output | 4 | Bass tone code |
| treble_code | output | 4 | Treble tone code |
| mute_l | output | 1 | Left speaker muted |
| mute_r | output | 1 | Right speaker muted |

## Verification
Each pin passes through two synchronizer flops and a one-sample agreement filter, and then the edge registers, so the block sees a pin edge about five to six clocks after it happens. The acknowledge therefore rises about six clocks after SCL falls. A setting changes two clocks after the filtered fall of the ninth SCL pulse: one clock for the commit pulse and one for the register. That puts every result within roughly ten clocks of the raw edge. The bench holds each SCL phase for 20 clocks. It reads the acknowledge in the middle of the ninth high phase, reads the settings while that pulse is still high to show that nothing has changed yet, and reads them again at least a full phase after the ninth fall or after STOP, when every result is settled.

// File: rtl/i2c_audio_pkg.sv
package i2c_audio_pkg;
  localparam int VOL_W    = 3;
  localparam int SPK_C_W  = 2;
  localparam int FINE_W   = 3;
  localparam int TONE_W   = 4;
  localparam int BYTE_W   = 8;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_ADDR,
    RX_DATA,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/i2c_line_conditioner.sv
module i2c_line_conditioner #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         held_q;
  logic         out_nxt;

  always_comb begin
    out_nxt = line_out;
    if (sync_q[TOP] == held_q) out_nxt = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '1;
      held_q   <= 1'b1;
      line_out <= 1'b1;
    end else begin
      sync_q   <= {sync_q[TOP-1:0], line_in};
      held_q   <= sync_q[TOP];
      line_out <= out_nxt;
    end
  end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2c_audio_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  output logic              ack_low,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              skipping
);
  localparam int          CNT_W     = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [BYTE_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] shift_q, shift_n;
  logic [BYTE_W-1:0] data_n;
  logic              in_ack_q, in_ack_n;
  logic              ack_n, valid_n;
  logic              scl_d, sda_d;
  logic              start_c, stop_c, rise_c, fall_c, active_c;

  assign start_c  = scl & scl_d & sda_d & ~sda;
  assign stop_c   = scl & scl_d & ~sda_d & sda;
  assign rise_c   = scl & ~scl_d;
  assign fall_c   = ~scl & scl_d;
  assign active_c = (state_q == RX_ADDR) || (state_q == RX_DATA);
  assign skipping = (state_q == RX_SKIP);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    shift_n  = shift_q;
    in_ack_n = in_ack_q;
    ack_n    = ack_low;
    valid_n  = 1'b0;
    data_n   = byte_data;
    if (start_c) begin
      state_n  = RX_ADDR;
      cnt_n    = '0;
      in_ack_n = 1'b0;
      ack_n    = 1'b0;
    end else if (stop_c) begin
      state_n  = RX_IDLE;
      cnt_n    = '0;
      in_ack_n = 1'b0;
      ack_n    = 1'b0;
    end else if (active_c) begin
      if (rise_c && (cnt_q < LAST_BIT)) begin
        shift_n = {shift_q[BYTE_W-2:0], sda};
        cnt_n   = cnt_q + 1'b1;
      end else if (fall_c) begin
        if (in_ack_q) begin
          ack_n    = 1'b0;
          in_ack_n = 1'b0;
          cnt_n    = '0;
          if (state_q == RX_ADDR) begin
            state_n = RX_DATA;
          end else begin
            valid_n = 1'b1;
            data_n  = shift_q;
          end
        end else if (cnt_q == LAST_BIT) begin
          if ((state_q == RX_DATA) || (shift_q == ADDR_WR)) begin
            ack_n    = 1'b1;
            in_ack_n = 1'b1;
          end else begin
            state_n = RX_SKIP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      in_ack_q   <= 1'b0;
      ack_low    <= 1'b0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      shift_q    <= shift_n;
      in_ack_q   <= in_ack_n;
      ack_low    <= ack_n;
      byte_valid <= valid_n;
      byte_data  <= data_n;
      scl_d      <= scl;
      sda_d      <= sda;
    end
  end
endmodule

// File: rtl/i2c_audio_settings.sv
module i2c_audio_settings
  import i2c_audio_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [BYTE_W-1:0]  cmd,
  output logic [VOL_W-1:0]   vol_coarse,
  output logic [FINE_W-1:0]  vol_fine,
  output logic [SPK_C_W-1:0] spk_l_coarse,
  output logic [FINE_W-1:0]  spk_l_fine,
  output logic [SPK_C_W-1:0] spk_r_coarse,
  output logic [FINE_W-1:0]  spk_r_fine,
  output logic               loud_on,
  output logic [TONE_W-1:0]  bass_code,
  output logic [TONE_W-1:0]  treble_code
);
  logic [VOL_W-1:0]   vc_n;
  logic [FINE_W-1:0]  vf_n, lf_n, rf_n;
  logic [SPK_C_W-1:0] lc_n, rc_n;
  logic               loud_n;
  logic [TONE_W-1:0]  bass_n, treb_n;

  always_comb begin
    vc_n   = vol_coarse;
    vf_n   = vol_fine;
    lc_n   = spk_l_coarse;
    lf_n   = spk_l_fine;
    rc_n   = spk_r_coarse;
    rf_n   = spk_r_fine;
    loud_n = loud_on;
    bass_n = bass_code;
    treb_n = treble_code;
    if (cmd_valid) begin
      if (cmd[7:6] == 2'b00) begin
        vc_n = cmd[5:3];
        vf_n = cmd[2:0];
      end else if (cmd[7:5] == 3'b010) begin
        loud_n = ~cmd[2];
      end else if (cmd[7:4] == 4'b0110) begin
        bass_n = cmd[3:0];
      end else if (cmd[7:4] == 4'b0111) begin
        treb_n = cmd[3:0];
      end else if (cmd[7:5] == 3'b100) begin
        lc_n = cmd[4:3];
        lf_n = cmd[2:0];
      end else if (cmd[7:5] == 3'b101) begin
        rc_n = cmd[4:3];
        rf_n = cmd[2:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_coarse   <= '1;
      vol_fine     <= '1;
      spk_l_coarse <= '1;
      spk_l_fine   <= '1;
      spk_r_coarse <= '1;
      spk_r_fine   <= '1;
      loud_on      <= 1'b0;
      bass_code    <= '1;
      treble_code  <= '1;
    end else begin
      vol_coarse   <= vc_n;
      vol_fine     <= vf_n;
      spk_l_coarse <= lc_n;
      spk_l_fine   <= lf_n;
      spk_r_coarse <= rc_n;
      spk_r_fine   <= rf_n;
      loud_on      <= loud_n;
      bass_code    <= bass_n;
      treble_code  <= treb_n;
    end
  end
endmodule

// File: rtl/i2c_audio_regbank.sv
module i2c_audio_regbank
  import i2c_audio_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h44,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_drive_low,
  output logic [VOL_W-1:0]   vol_coarse,
  output logic [FINE_W-1:0]  vol_fine,
  output logic [SPK_C_W-1:0] spk_l_coarse,
  output logic [FINE_W-1:0]  spk_l_fine,
  output logic [SPK_C_W-1:0] spk_r_coarse,
  output logic [FINE_W-1:0]  spk_r_fine,
  output logic               loud_on,
  output logic [TONE_W-1:0]  bass_code,
  output logic [TONE_W-1:0]  treble_code,
  output logic               mute_l,
  output logic               mute_r
);
  localparam int NUM_LINES = 2;

  logic [1:0]           rst_sync_q;
  logic                 rst_int_n;
  logic [NUM_LINES-1:0] raw_lines, clean_lines;
  logic                 byte_valid;
  logic [BYTE_W-1:0]    rx_byte;
  logic                 skipping;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_lines = {sda_in, scl_in};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_conditioner #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .line_in  (raw_lines[g]),
      .line_out (clean_lines[g])
    );
  end

  i2c_wr_target #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl        (clean_lines[0]),
    .sda        (clean_lines[1]),
    .ack_low    (sda_drive_low),
    .byte_valid (byte_valid),
    .byte_data  (rx_byte),
    .skipping   (skipping)
  );

  i2c_audio_settings u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cmd_valid    (byte_valid),
    .cmd          (rx_byte),
    .vol_coarse   (vol_coarse),
    .vol_fine     (vol_fine),
    .spk_l_coarse (spk_l_coarse),
    .spk_l_fine   (spk_l_fine),
    .spk_r_coarse (spk_r_coarse),
    .spk_r_fine   (spk_r_fine),
    .loud_on      (loud_on),
    .bass_code    (bass_code),
    .treble_code  (treble_code)
  );

  assign mute_l = (spk_l_coarse == '1) && (spk_l_fine == '1);
  assign mute_r = (spk_r_coarse == '1) && (spk_r_fine == '1);
endmodule

// File: rtl/i2c_audio_regbank_chk.sv
module i2c_audio_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_in,
  input logic        sda_drive_low,
  input logic        byte_valid,
  input logic        skipping,
  input logic [25:0] settings
);
  // R12: the acknowledge is asserted only while SCL is low
  a_r12_ack_set_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> !scl_in);

  // R12: the acknowledge is released only while SCL is low
  a_r12_ack_clr_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_low) |-> !scl_in);

  // R11: a data byte is committed only when its acknowledge ends
  a_r11_commit_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $fell(sda_drive_low));

  // R11: no setting moves without a committed byte
  a_r11_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |=> $stable(settings));

  // R3: an unselected transaction is never acknowledged
  a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
    skipping |-> !sda_drive_low);
endmodule

bind i2c_audio_regbank i2c_audio_regbank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .scl_in        (scl_in),
  .sda_drive_low (sda_drive_low),
  .byte_valid    (byte_valid),
  .skipping      (skipping),
  .settings      ({vol_coarse, vol_fine, spk_l_coarse, spk_l_fine,
                   spk_r_coarse, spk_r_fine, loud_on, bass_code, treble_code})
);

// File: tb/i2c_audio_regbank_bench.sv
module i2c_audio_regbank_bench;
  localparam int Q        = 20;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [2:0] vc; logic [2:0] vf;
    logic [1:0] lc; logic [2:0] lf;
    logic [1:0] rc; logic [2:0] rf;
    logic       loud;
    logic [3:0] bass; logic [3:0] treb;
    logic       ml; logic mr;
  } st_t;

  typedef struct packed {
    logic [7:0] cmd;
    st_t        exp;
  } vec_t;

  localparam st_t DEFAULTS = '{3'd7, 3'd7, 2'd3, 3'd7, 2'd3, 3'd7, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1};
  localparam int  NV = 11;
  localparam vec_t TBL [NV] = '{
    '{8'h2D, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd3, 3'd7, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1}}, // R4 volume
    '{8'h9A, '{3'd5, 3'd5, 2'd3, 3'd2, 2'd3, 3'd7, 1'b0, 4'hF, 4'hF, 1'b0, 1'b1}}, // R5 left, R6 unmute
    '{8'hA7, '{3'd5, 3'd5, 2'd3, 3'd2, 2'd0, 3'd7, 1'b0, 4'hF, 4'hF, 1'b0, 1'b0}}, // R5 right
    '{8'h40, '{3'd5, 3'd5, 2'd3, 3'd2, 2'd0, 3'd7, 1'b1, 4'hF, 4'hF, 1'b0, 1'b0}}, // R7 loudness on
    '{8'h63, '{3'd5, 3'd5, 2'd3, 3'd2, 2'd0, 3'd7, 1'b1, 4'h3, 4'hF, 1'b0, 1'b0}}, // R8 bass
    '{8'h7C, '{3'd5, 3'd5, 2'd3, 3'd2, 2'd0, 3'd7, 1'b1, 4'h3, 4'hC, 1'b0, 1'b0}}, // R8 treble
    '{8'h9F, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd0, 3'd7, 1'b1, 4'h3, 4'hC, 1'b1, 1'b0}}, // R6 left mute
    '{8'hC5, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd0, 3'd7, 1'b1, 4'h3, 4'hC, 1'b1, 1'b0}}, // R9 no effect
    '{8'hBF, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd3, 3'd7, 1'b1, 4'h3, 4'hC, 1'b1, 1'b1}}, // R6 right mute
    '{8'h44, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd3, 3'd7, 1'b0, 4'h3, 4'hC, 1'b1, 1'b1}}, // R7 loudness off
    '{8'h5B, '{3'd5, 3'd5, 2'd3, 3'd7, 2'd3, 3'd7, 1'b1, 4'h3, 4'hC, 1'b1, 1'b1}}  // R7 x bits ignored
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_drive_low;
  logic sda_line;
  logic [2:0] vol_coarse, vol_fine, spk_l_fine, spk_r_fine;
  logic [1:0] spk_l_coarse, spk_r_coarse;
  logic       loud_on, mute_l, mute_r;
  logic [3:0] bass_code, treble_code;
  st_t        got;
  int checks = 0;
  int fails  = 0;
  logic ak;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_drive_low;
  assign got = '{vol_coarse, vol_fine, spk_l_coarse, spk_l_fine, spk_r_coarse,
                 spk_r_fine, loud_on, bass_code, treble_code, mute_l, mute_r};

  i2c_audio_regbank u_i2c_audio_regbank (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_drive_low(sda_drive_low),
    .vol_coarse(vol_coarse), .vol_fine(vol_fine),
    .spk_l_coarse(spk_l_coarse), .spk_l_fine(spk_l_fine),
    .spk_r_coarse(spk_r_coarse), .spk_r_fine(spk_r_fine),
    .loud_on(loud_on), .bass_code(bass_code), .treble_code(treble_code),
    .mute_l(mute_l), .mute_r(mute_r)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_st(input string req, input st_t exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s settings actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    sda_m = 1'b1; wait_n(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wait_n(Q);
      scl_m = 1'b1;   wait_n(Q);
      scl_m = 1'b0;   wait_n(Q);
    end
  endtask

  task automatic ack_clock(output logic acked);
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q / 2);
    acked = ~sda_line;
    wait_n(Q / 2);
    scl_m = 1'b0; wait_n(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    ack_clock(acked);
  endtask

  initial begin
    wait_n(WATCHDOG);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    st_t cur;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    check_st("R1 reset defaults", DEFAULTS);

    // table walk: one command per transaction
    for (int i = 0; i < NV; i++) begin
      bus_start();
      send_byte(8'h88, ak);
      check_bit("R2 address ack", ak, 1'b1);
      send_byte(TBL[i].cmd, ak);
      check_bit("R2 data ack", ak, 1'b1);
      bus_stop();
      wait_n(Q);
      check_st("R4-table entry", TBL[i].exp);
    end
    cur = TBL[NV-1].exp;

    // R10: three commands in one transaction, applied in order
    bus_start();
    send_byte(8'h88, ak);
    send_byte(8'h00, ak);
    send_byte(8'hB8, ak);
    send_byte(8'h68, ak);
    bus_stop();
    wait_n(Q);
    cur.vc = 3'd0; cur.vf = 3'd0; cur.rc = 2'd3; cur.rf = 3'd0; cur.mr = 1'b0; cur.bass = 4'h8;
    check_st("R10 multi-byte", cur);

    // R3: wrong address, no ack, following byte ignored
    bus_start();
    send_byte(8'h8A, ak);
    check_bit("R3 wrong address no ack", ak, 1'b0);
    send_byte(8'h3F, ak);
    check_bit("R3 skipped byte no ack", ak, 1'b0);
    bus_stop();
    wait_n(Q);
    check_st("R3 wrong address ignored", cur);

    // R3: read bit set
    bus_start();
    send_byte(8'h89, ak);
    check_bit("R3 read bit no ack", ak, 1'b0);
    send_byte(8'h3F, ak);
    bus_stop();
    wait_n(Q);
    check_st("R3 read request ignored", cur);

    // R11: STOP mid-byte discards the partial byte
    bus_start();
    send_byte(8'h88, ak);
    send_bits(8'h3F, 4);
    bus_stop();
    wait_n(Q);
    check_st("R11 partial byte at STOP", cur);

    // R11: repeated START mid-byte, then a full command
    bus_start();
    send_byte(8'h88, ak);
    send_bits(8'h3F, 3);
    bus_start();
    send_byte(8'h88, ak);
    send_byte(8'h12, ak);
    bus_stop();
    wait_n(Q);
    cur.vc = 3'd2; cur.vf = 3'd2;
    check_st("R11 repeated START recovery", cur);

    // R11: no change before the acknowledge clock ends
    bus_start();
    send_byte(8'h88, ak);
    send_bits(8'h09, 8);
    sda_m = 1'b1; wait_n(Q);
    scl_m = 1'b1; wait_n(Q);
    check_st("R11 held during ack", cur);
    scl_m = 1'b0; wait_n(Q);
    cur.vc = 3'd1; cur.vf = 3'd1;
    check_st("R11 applied after ack", cur);
    bus_stop();

    // R1: reset mid-run restores defaults
    wait_n(Q);
    rst_n = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    check_st("R1 defaults after reset", DEFAULTS);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule